// File: doc/BRIEF.md
# MSI Device-Identifier Tagging Bridge

The bridge sits between peripherals that raise message-signalled interrupts and an interrupt translation service. That service needs a device identifier with every doorbell write. The peripherals cannot provide one. Each peripheral is instead programmed to write its interrupt payload into its own 32-bit word slot inside a dedicated address window. The bridge works out the identifier from the word offset of the write within that window. It then issues a single write of the unchanged payload to a fixed doorbell address, with the identifier on a sideband field.

Requests come in on a valid/ready write channel that carries an address, a 32-bit data word and four byte strobes. The bridge finishes every accepted request with a one-cycle response pulse that carries a two-bit status code. A write that is malformed, or that falls outside the window, gets a non-zero code and is dropped. A well-formed write waits in a single-entry output register until the downstream valid/ready channel takes it. While that register is full and stalled, the input is held off.

Top module: `msi_tag_bridge`

## Requirements
- R1: A write is in the window when WIN_BASE <= address < WIN_BASE + WIN_SPAN (defaults 0x00C0_0000 and 0x0100_0000). An accepted write outside the window is not forwarded, and its response code is 2'b01. This check has the highest priority.
- R2: The forwarded device identifier equals (address - WIN_BASE) >> 2. The request carries no identifier field at all.
- R3: out_data is always the accepted data word, unchanged. Whenever out_valid is high, out_addr equals the DOORBELL parameter (default 0x0083_0040), whatever the input address was.
- R4: Each accepted write with code 2'b00 produces exactly one output transfer. Output transfers come out in the order the writes were accepted, and nothing else ever appears on the output.
- R5: An in-window write is rejected with code 2'b10 and not forwarded if its address bits [1:0] are non-zero or if in_strb is not 4'b1111.
- R6: An in-window, well-formed write whose identifier needs more than ID_W bits is rejected with code 2'b11 and not forwarded. It is never truncated.
- R7: Each accepted request (in_valid and in_ready both high at a clock edge) makes rsp_valid high for exactly the following cycle, carrying that request's code. A forwarded write gets code 2'b00. rsp_valid is low in every other cycle.
- R8: in_ready is low exactly while out_valid is high and out_ready is low. During such a stall, out_valid, out_data and out_devid hold their values.
- R9: An accepted write shows up on the output no earlier than the cycle after it is accepted. There is no combinational path from the input to the output.
- R10: A synchronous active-low reset clears the pending output entry and the response. After any clock edge with rst_n low, out_valid and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming write request valid |
| in_ready | output | 1 | Bridge can take a request this cycle |
| in_addr | input | ADDR_W | Byte address of the incoming write |
| in_data | input | 32 | Interrupt payload word |
| in_strb | input | 4 | Byte strobes of the incoming write |
| out_valid | output | 1 | Doorbell write pending |
| out_ready | input | 1 | Downstream takes the doorbell write |
| out_addr | output | ADDR_W | Fixed doorbell address |
| out_data | output | 32 | Forwarded payload |
| out_devid | output | ID_W | Derived device identifier sideband |
| rsp_valid | output | 1 | Completion pulse for an accepted request |
| rsp_code | output | 2 | 00 forwarded, 01 out of window, 10 misaligned or partial strobe, 11 identifier too wide |

## Verification
The hardest case to reach from the ports is a new request accepted in the same cycle that a stalled entry finally drains. The register must load the new entry and release the old one at the same edge, and neither may be lost or duplicated. The stimulus toggles out_ready at random while it offers back-to-back requests most cycles, so stalls often end with a request already waiting. A reference queue in the bench confirms the order and count of the forwarded writes. The identifier overflow code cannot occur with the default widths, so a second instance with an 8-bit identifier is driven just below and at its first overflowing slot.

// File: rtl/msi_tag_pkg.sv
package msi_tag_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned WORD_SHIFT = $clog2(STRB_W);

  typedef enum logic [1:0] {
    RSP_OK     = 2'b00,
    RSP_RANGE  = 2'b01,
    RSP_FORMAT = 2'b10,
    RSP_IDWIDE = 2'b11
  } rsp_code_e;

  // Window membership: base <= addr < base + span
  function automatic logic win_hit(input logic [63:0] addr,
                                   input logic [63:0] base,
                                   input logic [63:0] span);
    logic [63:0] off;
    off = addr - base;
    return (addr >= base) && (off < span);
  endfunction

  // Word slot index inside the window
  function automatic logic [63:0] slot_index(input logic [63:0] addr,
                                             input logic [63:0] base);
    return (addr - base) >> WORD_SHIFT;
  endfunction

  // Does an index fit in id_w bits
  function automatic logic id_fits(input logic [63:0] idx,
                                   input int unsigned id_w);
    return (idx >> id_w) == 64'd0;
  endfunction

  function automatic logic word_aligned(input logic [63:0] addr);
    return addr[WORD_SHIFT-1:0] == '0;
  endfunction

  function automatic logic full_strobe(input logic [STRB_W-1:0] strb);
    return &strb;
  endfunction

endpackage

// File: rtl/msi_win_decode.sv
module msi_win_decode
  import msi_tag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [63:0] WIN_BASE = 64'h0000_0000_00C0_0000,
  parameter logic [63:0] WIN_SPAN = 64'h0000_0000_0100_0000,
  parameter int unsigned ID_W     = 22
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [STRB_W-1:0] strb,
  output rsp_code_e         code,
  output logic [ID_W-1:0]   devid
);

  logic [63:0] addr_w;
  logic [63:0] idx;
  logic        hit;
  logic        fmt_ok;
  logic        wide_ok;

  assign addr_w  = 64'(addr);
  assign hit     = win_hit(addr_w, WIN_BASE, WIN_SPAN);
  assign fmt_ok  = word_aligned(addr_w) && full_strobe(strb);
  assign idx     = slot_index(addr_w, WIN_BASE);
  assign wide_ok = id_fits(idx, ID_W);
  assign devid   = idx[ID_W-1:0];

  // Priority: window, then format, then identifier width
  always_comb begin
    if (!hit)          code = RSP_RANGE;
    else if (!fmt_ok)  code = RSP_FORMAT;
    else if (!wide_ok) code = RSP_IDWIDE;
    else               code = RSP_OK;
  end

endmodule

// File: rtl/msi_fwd_slot.sv
module msi_fwd_slot
  import msi_tag_pkg::*;
#(
  parameter int unsigned ID_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [ID_W-1:0]   load_id,
  input  logic              take,
  output logic              can_take,
  output logic              drain,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic [ID_W-1:0]   id
);

  assign drain    = valid && take;
  assign can_take = !valid || take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      id    <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      id    <= load_id;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/msi_resp_unit.sv
module msi_resp_unit
  import msi_tag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  rsp_code_e code_in,
  output logic      rsp_valid,
  output logic [1:0] rsp_code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
    end else begin
      rsp_valid <= accept;
      rsp_code  <= accept ? code_in : RSP_OK;
    end
  end

endmodule

// File: rtl/msi_tag_bridge.sv
module msi_tag_bridge
  import msi_tag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [63:0] WIN_BASE = 64'h0000_0000_00C0_0000,
  parameter logic [63:0] WIN_SPAN = 64'h0000_0000_0100_0000,
  parameter logic [63:0] DOORBELL = 64'h0000_0000_0083_0040,
  parameter int unsigned ID_W     = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [31:0]       in_data,
  input  logic [3:0]        in_strb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [31:0]       out_data,
  output logic [ID_W-1:0]   out_devid,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code
);

  // Named internal events, used by the bound checker
  rsp_code_e         dec_code;
  logic [ID_W-1:0]   dec_id;
  logic              accept;
  logic              fwd_load;
  logic              fwd_drain;

  msi_win_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WIN_SPAN(WIN_SPAN),
    .ID_W    (ID_W)
  ) u_dec (
    .addr (in_addr),
    .strb (in_strb),
    .code (dec_code),
    .devid(dec_id)
  );

  assign accept   = in_valid && in_ready;
  assign fwd_load = accept && (dec_code == RSP_OK);

  msi_fwd_slot #(
    .ID_W(ID_W)
  ) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fwd_load),
    .load_data(in_data),
    .load_id  (dec_id),
    .take     (out_ready),
    .can_take (in_ready),
    .drain    (fwd_drain),
    .valid    (out_valid),
    .data     (out_data),
    .id       (out_devid)
  );

  msi_resp_unit u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .code_in  (dec_code),
    .rsp_valid(rsp_valid),
    .rsp_code (rsp_code)
  );

  assign out_addr = ADDR_W'(DOORBELL);

endmodule

// File: rtl/msi_tag_bridge_chk.sv
module msi_tag_bridge_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [63:0] DOORBELL = 64'h0000_0000_0083_0040,
  parameter int unsigned ID_W     = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [31:0]       out_data,
  input logic [ID_W-1:0]   out_devid,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic              accept,
  input logic              fwd_load,
  input logic              fwd_drain
);

  // R8: a stalled entry keeps its content
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_devid)));

  // R4: a new entry only lands in a free or draining register
  a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_load |-> (!out_valid || fwd_drain));

  // R3: fixed doorbell target
  a_r3_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr == ADDR_W'(DOORBELL)));

  // R7: one response per accepted request, and none otherwise
  a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  a_r7_rsp_only: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  // R1: forwarded writes complete with the OK code
  a_r1_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_load |=> (rsp_code == 2'b00));

  // R9: output appears the cycle after a load, never without one
  a_r9_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_load |=> out_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fwd_load));

  // R10: reset empties the block
  a_r10_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !rsp_valid));

endmodule

bind msi_tag_bridge msi_tag_bridge_chk #(
  .ADDR_W  (ADDR_W),
  .DOORBELL(DOORBELL),
  .ID_W    (ID_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_addr (out_addr),
  .out_data (out_data),
  .out_devid(out_devid),
  .rsp_valid(rsp_valid),
  .rsp_code (rsp_code),
  .accept   (accept),
  .fwd_load (fwd_load),
  .fwd_drain(fwd_drain)
);

// File: tb/msi_tag_bridge_bench.sv
module msi_tag_bridge_bench;

  localparam logic [31:0] BASE = 32'h00C0_0000;
  localparam logic [31:0] SPAN = 32'h0100_0000;
  localparam logic [31:0] DB   = 32'h0083_0040;
  localparam int          IDW  = 22;
  localparam int          NIDW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            in_valid = 1'b0, in_ready;
  logic [31:0]     in_addr = '0, in_data = '0;
  logic [3:0]      in_strb = '0;
  logic            out_valid, out_ready = 1'b0;
  logic [31:0]     out_addr, out_data;
  logic [IDW-1:0]  out_devid;
  logic            rsp_valid;
  logic [1:0]      rsp_code;

  msi_tag_bridge u_msi_tag_bridge (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_data(in_data), .in_strb(in_strb),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .out_devid(out_devid),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code)
  );

  logic            n_in_valid = 1'b0, n_in_ready;
  logic [31:0]     n_in_addr = '0, n_in_data = '0;
  logic            n_out_valid;
  logic [31:0]     n_out_addr, n_out_data;
  logic [NIDW-1:0] n_out_devid;
  logic            n_rsp_valid;
  logic [1:0]      n_rsp_code;

  msi_tag_bridge #(.ID_W(NIDW)) u_msi_tag_bridge_narrow (
    .clk(clk), .rst_n(rst_n),
    .in_valid(n_in_valid), .in_ready(n_in_ready), .in_addr(n_in_addr),
    .in_data(n_in_data), .in_strb(4'hF),
    .out_valid(n_out_valid), .out_ready(1'b1), .out_addr(n_out_addr),
    .out_data(n_out_data), .out_devid(n_out_devid),
    .rsp_valid(n_rsp_valid), .rsp_code(n_rsp_code)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic chk(input bit ok, input string tag,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Expected status code, restated from the requirements
  function automatic logic [1:0] exp_code(input logic [31:0] a,
                                          input logic [3:0] s, input int idw);
    longint off;
    off = longint'(a) - longint'(BASE);
    if (off < 0 || off >= longint'(SPAN)) return 2'b01;
    if ((a % 4) != 0 || s != 4'hF)        return 2'b10;
    if ((off / 4) >= (longint'(1) << idw)) return 2'b11;
    return 2'b00;
  endfunction

  function automatic longint exp_id(input logic [31:0] a);
    return (longint'(a) - longint'(BASE)) / 4;
  endfunction

  // Reference model state
  logic [63:0] q[$];
  bit          rsp_pend = 0;
  logic [1:0]  rsp_exp  = 2'b00;
  bit          stalled  = 0;
  logic [31:0] st_data  = '0;
  logic [IDW-1:0] st_id = '0;

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] s, input bit ordy);
    logic [63:0] e;
    logic [1:0]  c;
    @(negedge clk);
    if (rsp_pend) begin
      chk(rsp_valid == 1'b1, "R7 rsp_valid", longint'(rsp_valid), 1);
      chk(rsp_code == rsp_exp, "R7 rsp_code", longint'(rsp_code), longint'(rsp_exp));
    end else begin
      chk(rsp_valid == 1'b0, "R7 idle rsp", longint'(rsp_valid), 0);
    end
    if (stalled) begin
      chk(out_valid && out_data == st_data && out_devid == st_id, "R8 hold",
          longint'(out_data), longint'(st_data));
    end
    in_valid  = v;
    in_addr   = a;
    in_data   = d;
    in_strb   = s;
    out_ready = ordy;
    #1;
    chk(in_ready == !(out_valid && !out_ready), "R8 in_ready",
        longint'(in_ready), longint'(!(out_valid && !out_ready)));
    if (out_valid) begin
      chk(out_addr == DB, "R3 doorbell", longint'(out_addr), longint'(DB));
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4 spurious output", 1, 0);
      end else begin
        e = q.pop_front();
        chk(out_data == e[31:0], "R3 data", longint'(out_data), longint'(e[31:0]));
        chk(out_devid == e[32+IDW-1:32], "R2 devid", longint'(out_devid),
            longint'(e[32+IDW-1:32]));
      end
    end
    stalled = out_valid && !out_ready;
    st_data = out_data;
    st_id   = out_devid;
    if (v && in_ready) begin
      c = exp_code(a, s, IDW);
      rsp_pend = 1;
      rsp_exp  = c;
      if (c == 2'b00) q.push_back({32'(exp_id(a)), d});
    end else begin
      rsp_pend = 0;
    end
  endtask

  function automatic logic [31:0] rand_addr(output logic [3:0] s);
    int k;
    k = $urandom_range(0, 9);
    s = 4'hF;
    case (k)
      5: return BASE + ($urandom_range(0, SPAN / 4 - 1) << 2) + $urandom_range(1, 3);
      6: return $urandom_range(0, BASE - 1);
      7: return BASE + SPAN + $urandom_range(0, 32'h00FF_FFFF);
      8: begin
        s = 4'($urandom_range(0, 14));
        return BASE + ($urandom_range(0, SPAN / 4 - 1) << 2);
      end
      9: begin
        case ($urandom_range(0, 3))
          0: return BASE;
          1: return BASE + SPAN - 4;
          2: return BASE + SPAN;
          default: return BASE - 4;
        endcase
      end
      default: return BASE + ($urandom_range(0, SPAN / 4 - 1) << 2);
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [3:0]  s;
    logic [31:0] a;
    void'($urandom(32'h1D5E_7A11));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset out_valid", longint'(out_valid), 0);
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", longint'(rsp_valid), 0);
    rst_n = 1'b1;

    // R9: no same-cycle path, output appears one cycle later
    in_valid = 1; in_addr = BASE + 32'h40; in_data = 32'hCAFE_0001; in_strb = 4'hF;
    out_ready = 1;
    #1;
    chk(out_valid == 1'b0, "R9 no bypass", longint'(out_valid), 0);
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 1'b1, "R9 next cycle", longint'(out_valid), 1);
    chk(out_devid == 22'h10, "R2 devid 0x40", longint'(out_devid), 32'h10);
    chk(rsp_valid && rsp_code == 2'b00, "R7 ok code", longint'(rsp_code), 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);

    // Directed window edges and formats (R1, R5)
    step(1, BASE,             32'h1111_0000, 4'hF, 1);
    step(1, BASE + SPAN - 4,  32'h2222_0000, 4'hF, 1);
    step(1, BASE + SPAN,      32'h3333_0000, 4'hF, 1);
    step(1, BASE - 4,         32'h4444_0000, 4'hF, 1);
    step(1, BASE + 2,         32'h5555_0000, 4'hF, 1);
    step(1, BASE + 8,         32'h6666_0000, 4'h7, 1);
    step(1, BASE - 1,         32'h7777_0000, 4'h0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);

    // Random traffic with random backpressure (R1-R9)
    for (int i = 0; i < 3000; i++) begin
      a = rand_addr(s);
      step($urandom_range(0, 3) != 0, a, $urandom, s, $urandom_range(0, 2) != 0);
    end
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1);
    chk(q.size() == 0, "R4 all forwarded once", longint'(q.size()), 0);

    // R10: reset while an entry is stalled
    step(1, BASE + 32'h100, 32'hDEAD_BEEF, 4'hF, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 stalled before reset", longint'(out_valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 clears entry", longint'(out_valid), 0);
    chk(rsp_valid == 1'b0, "R10 clears rsp", longint'(rsp_valid), 0);
    rst_n = 1'b1;
    q.delete();
    rsp_pend = 0;
    stalled  = 0;
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);

    // R6: narrow identifier instance, 8-bit identifier
    @(negedge clk);
    n_in_valid = 1; n_in_addr = BASE + 32'h3FC; n_in_data = 32'hA5A5_0001;
    @(negedge clk);
    n_in_valid = 0;
    chk(n_rsp_valid && n_rsp_code == 2'b00, "R6 last fitting slot code",
        longint'(n_rsp_code), 0);
    chk(n_out_valid && n_out_devid == 8'hFF, "R6 last fitting id",
        longint'(n_out_devid), 255);
    @(negedge clk);
    n_in_valid = 1; n_in_addr = BASE + 32'h400; n_in_data = 32'hA5A5_0002;
    @(negedge clk);
    n_in_valid = 0;
    chk(n_rsp_valid && n_rsp_code == 2'b11, "R6 overflow code",
        longint'(n_rsp_code), 3);
    chk(n_out_valid == 1'b0, "R6 overflow not forwarded", longint'(n_out_valid), 0);
    @(negedge clk);
    chk(n_out_valid == 1'b0, "R6 still nothing forwarded", longint'(n_out_valid), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule